// File: doc/BRIEF.md
# Masked Four-Lane Vector Execution Unit

This unit runs one arithmetic or compare operation across a wide vector register. The register is split into equal lanes, and each lane has its own ALU. Every lane applies the same opcode in the same cycle. A per-lane enable mask decides which lanes write a new result. A lane that is switched off returns the destination value that was supplied with the instruction. A data-dependent branch is therefore run as two issues. The first issue runs the taken path under the condition mask. The second runs the other path with the complement of that mask, selected by one input bit, and uses the first result as its destination.

Every operation passes through the same fixed-depth pipeline, including the multiplier. An instruction can therefore issue on every cycle, results come out in issue order, and no two results ever need the output in the same cycle. Compares return an all-ones or all-zero value per lane, together with a lane flag vector. That flag vector can be fed straight back as the mask for a later branch.

Top module: `simd_lane_unit`

## Requirements
- R1: With defaults, the 256-bit operands form four 64-bit lanes, lane i at bits [64i+63:64i]. All lanes apply the same opcode, and no result bit of one lane depends on another lane's operands.
- R2: Opcode 0 (add) writes a+b modulo 2^64 into each enabled lane.
- R3: Opcode 1 (subtract) writes a-b modulo 2^64 into each enabled lane.
- R4: Opcode 2 (multiply) writes the low 64 bits of a*b into each enabled lane. A multiply may issue on every cycle.
- R5: Opcodes 3 (equal), 4 (signed less-than) and 5 (unsigned less-than) write all ones into an enabled lane where a relation b holds, and zero where it does not. Flag bit i is 1 exactly when lane i is enabled and its relation holds. Every other opcode gives flags of zero.
- R6: A lane whose effective enable bit is 0 outputs its in_dst lane unchanged.
- R7: With in_else=0 the effective enable is in_mask; with in_else=1 it is ~in_mask. A "then" issue with mask m, followed by an "else" issue with mask m that takes the first result as destination, merges the two paths lane by lane.
- R8: out_valid is high exactly 4 cycles after each cycle in which in_valid was high. Results leave in issue order, including during back-to-back issue.
- R9: Synchronous active-high reset clears all in-flight valid bits, so out_valid is 0 in the cycle after reset and no instruction issued before reset ever emerges.
- R10: Opcodes 6 and 7 are reserved. They leave every lane equal to in_dst and give flags of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is issued this cycle |
| in_op | input | 3 | Opcode |
| in_else | input | 1 | Use the complement of in_mask as the lane enable |
| in_mask | input | 4 | Lane enable / branch condition mask |
| in_a | input | 256 | First source vector |
| in_b | input | 256 | Second source vector |
| in_dst | input | 256 | Current destination contents, kept in disabled lanes |
| out_valid | output | 1 | Result vector is valid |
| out_data | output | 256 | Result vector after masked writeback |
| out_flags | output | 4 | Per-lane compare result, gated by the lane enable |

## Verification
The checker assumes in_valid, in_op, in_mask and in_else are known whenever reset is low. It also assumes the opcode presented with a valid instruction is stable in the issuing cycle. Results are not tied to any handshake, so the checker assumes the consumer takes every result in the cycle it appears. The stimulus satisfies this by driving every input fully on the falling edge, never leaving a control input unknown, and collecting every result the cycle it comes out.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int unsigned OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD   = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB   = 3'd1;
  localparam logic [OP_W-1:0] OP_MUL   = 3'd2;
  localparam logic [OP_W-1:0] OP_CMPEQ = 3'd3;
  localparam logic [OP_W-1:0] OP_CMPLT = 3'd4;
  localparam logic [OP_W-1:0] OP_CMPLTU = 3'd5;

  function automatic logic op_is_cmp(input logic [OP_W-1:0] op);
    return (op == OP_CMPEQ) || (op == OP_CMPLT) || (op == OP_CMPLTU);
  endfunction

  function automatic logic op_writes(input logic [OP_W-1:0] op);
    return op <= OP_CMPLTU;
  endfunction

endpackage

// File: rtl/simd_delay.sv
module simd_delay #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [WIDTH-1:0] stage [DEPTH];
      always_ff @(posedge clk) stage[0] <= d;
      for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) stage[i] <= stage[i-1];
      end
      assign q = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned LAT = 4
) (
  input  logic            clk,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    dst_i,
  input  logic            en_i,
  output logic [W-1:0]    res_o,
  output logic            flag_o
);

  localparam int unsigned TAIL   = (LAT > 3) ? LAT - 3 : 0;
  localparam int unsigned PACK_W = 2 * W + 4;

  // stage 1: operand capture
  logic [OP_W-1:0] s1_op;
  logic [W-1:0]    s1_a, s1_b, s1_dst;
  logic            s1_en;

  always_ff @(posedge clk) begin
    s1_op  <= op_i;
    s1_a   <= a_i;
    s1_b   <= b_i;
    s1_dst <= dst_i;
    s1_en  <= en_i;
  end

  // stage 1 -> 2: lane ALU and multiplier
  logic [W-1:0] sum, diff, prod, val;
  logic         cond;

  always_comb begin
    sum  = s1_a + s1_b;
    diff = s1_a - s1_b;
    prod = s1_a * s1_b;
    unique case (s1_op)
      OP_CMPEQ:  cond = (s1_a == s1_b);
      OP_CMPLT:  cond = ($signed(s1_a) < $signed(s1_b));
      OP_CMPLTU: cond = (s1_a < s1_b);
      default:   cond = 1'b0;
    endcase
    unique case (s1_op)
      OP_ADD:  val = sum;
      OP_SUB:  val = diff;
      OP_MUL:  val = prod;
      default: val = {W{cond}};
    endcase
  end

  logic [W-1:0] s2_val, s2_dst;
  logic         s2_cond, s2_wr, s2_cmp, s2_en;

  always_ff @(posedge clk) begin
    s2_val  <= val;
    s2_dst  <= s1_dst;
    s2_cond <= cond;
    s2_wr   <= op_writes(s1_op);
    s2_cmp  <= op_is_cmp(s1_op);
    s2_en   <= s1_en;
  end

  // balancing delay so every opcode has the same latency
  logic [PACK_W-1:0] pk_in, pk_out;
  logic [W-1:0]      t_val, t_dst;
  logic              t_cond, t_wr, t_cmp, t_en;

  assign pk_in = {s2_val, s2_dst, s2_cond, s2_wr, s2_cmp, s2_en};

  simd_delay #(.WIDTH(PACK_W), .DEPTH(TAIL)) u_tail (
    .clk (clk),
    .d   (pk_in),
    .q   (pk_out)
  );

  assign {t_val, t_dst, t_cond, t_wr, t_cmp, t_en} = pk_out;

  // final stage: masked writeback
  always_ff @(posedge clk) begin
    res_o  <= (t_en && t_wr) ? t_val : t_dst;
    flag_o <= t_en & t_cmp & t_cond;
  end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 64,
  parameter int unsigned LAT    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              in_op,
  input  logic                    in_else,
  input  logic [LANES-1:0]        in_mask,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic [LANES*LANE_W-1:0] in_dst,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data,
  output logic [LANES-1:0]        out_flags
);

  logic [LANES-1:0] lane_en;
  logic [LAT-1:0]   vpipe;

  assign lane_en = in_else ? ~in_mask : in_mask;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      simd_lane_alu #(.W(LANE_W), .LAT(LAT)) u_alu (
        .clk    (clk),
        .op_i   (in_op),
        .a_i    (in_a[i*LANE_W +: LANE_W]),
        .b_i    (in_b[i*LANE_W +: LANE_W]),
        .dst_i  (in_dst[i*LANE_W +: LANE_W]),
        .en_i   (lane_en[i]),
        .res_o  (out_data[i*LANE_W +: LANE_W]),
        .flag_o (out_flags[i])
      );
    end
  endgenerate

endmodule

// File: rtl/simd_lane_unit_chk.sv
module simd_lane_unit_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 64,
  parameter int unsigned LAT    = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [2:0]              in_op,
  input logic                    in_else,
  input logic [LANES-1:0]        in_mask,
  input logic [LANES*LANE_W-1:0] in_dst,
  input logic                    out_valid,
  input logic [LANES*LANE_W-1:0] out_data,
  input logic [LANES-1:0]        out_flags
);

  logic [LAT-1:0]          vh;
  logic [LANES-1:0]        mh  [LAT];
  logic [2:0]              oph [LAT];
  logic [LANES*LANE_W-1:0] dh  [LAT];

  always_ff @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[LAT-2:0], in_valid};
    mh[0]  <= in_else ? ~in_mask : in_mask;
    oph[0] <= in_op;
    dh[0]  <= in_dst;
    for (int i = 1; i < LAT; i++) begin
      mh[i]  <= mh[i-1];
      oph[i] <= oph[i-1];
      dh[i]  <= dh[i-1];
    end
  end

  logic keep_ok, flags_ok;
  always_comb begin
    keep_ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (!mh[LAT-1][i] || oph[LAT-1] > 3'd5)
        if (out_data[i*LANE_W +: LANE_W] != dh[LAT-1][i*LANE_W +: LANE_W])
          keep_ok = 1'b0;
    end
    flags_ok = ((out_flags & ~mh[LAT-1]) == '0) &&
               ((oph[LAT-1] >= 3'd3 && oph[LAT-1] <= 3'd5) || out_flags == '0);
  end

  // R8: valid emerges a fixed LAT cycles after issue
  p_valid_latency_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LAT-1]);

  // R9: reset flushes in-flight results
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R6, R10: lanes that are off, or reserved opcodes, keep the destination
  p_masked_keep_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> keep_ok);

  // R5, R7: flags only in enabled lanes and only for compares
  p_flags_in_mask_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> flags_ok);

  // R9: no valid output without a matching issue
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !vh[LAT-1] |-> !out_valid);

endmodule

bind simd_lane_unit simd_lane_unit_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .LAT(LAT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_else   (in_else),
  .in_mask   (in_mask),
  .in_dst    (in_dst),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_flags (out_flags)
);

// File: tb/simd_lane_unit_tb.sv
module simd_lane_unit_tb;

  localparam int LANES = 4;
  localparam int W     = 64;
  localparam int LAT   = 4;
  localparam int VW    = LANES * W;
  localparam int SBN   = 4096;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic          in_else = 1'b0;
  logic [3:0]    in_mask = '0;
  logic [VW-1:0] in_a = '0, in_b = '0, in_dst = '0;
  logic          out_valid;
  logic [VW-1:0] out_data;
  logic [3:0]    out_flags;

  simd_lane_unit #(.LANES(LANES), .LANE_W(W), .LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_else(in_else), .in_mask(in_mask), .in_a(in_a), .in_b(in_b),
    .in_dst(in_dst), .out_valid(out_valid), .out_data(out_data),
    .out_flags(out_flags)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  logic          flushing = 1'b0;

  logic [VW-1:0] sb_d   [SBN];
  logic [3:0]    sb_f   [SBN];
  logic [3:0]    sb_m   [SBN];
  logic [2:0]    sb_op  [SBN];
  int            sb_cyc [SBN];
  int            sb_tag [SBN];
  int wr = 0, rd = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op, input int tg);
    if (tg == 1) return "R1";
    if (tg == 7) return "R7";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4, 3'd5: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [W-1:0] gv(input int k, input int lane, input int which);
    logic [31:0] h;
    case ((k + lane + which) % 6)
      0: return '1;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'd1;
      default: begin
        h = 32'(k) * 32'h9E3779B9 ^ 32'(lane * 977 + which * 131071);
        return {h, h ^ 32'h5bd1e995} + 64'(k);
      end
    endcase
  endfunction

  // expected lane result when enabled, and relation
  function automatic logic [W:0] lane_calc(input logic [2:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic [W-1:0] d);
    logic c;
    case (op)
      3'd0: return {1'b0, a + b};
      3'd1: return {1'b0, a - b};
      3'd2: return {1'b0, 64'((a * b) & 64'hFFFF_FFFF_FFFF_FFFF)};
      3'd3: begin c = (a == b); return {c, {W{c}}}; end
      3'd4: begin c = ($signed(a) < $signed(b)); return {c, {W{c}}}; end
      3'd5: begin c = (a < b); return {c, {W{c}}}; end
      default: return {1'b0, d};
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [VW-1:0] a,
                       input logic [VW-1:0] b, input logic [VW-1:0] d,
                       input logic [3:0] m, input logic els, input int tg);
    logic [3:0]    em;
    logic [VW-1:0] ed;
    logic [3:0]    ef;
    logic [W:0]    r;
    em = els ? ~m : m;
    ef = '0;
    ed = d;
    for (int i = 0; i < LANES; i++) begin
      r = lane_calc(op, a[i*W +: W], b[i*W +: W], d[i*W +: W]);
      if (em[i]) begin
        ed[i*W +: W] = r[W-1:0];
        ef[i] = r[W];
      end
    end
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_dst = d;
    in_mask = m; in_else = els;
    sb_d[wr % SBN] = ed; sb_f[wr % SBN] = ef; sb_m[wr % SBN] = em;
    sb_op[wr % SBN] = op; sb_cyc[wr % SBN] = cyc; sb_tag[wr % SBN] = tg;
    wr++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // result collector
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (flushing || rd == wr) begin
        chk(1'b0, "R9", "unexpected out_valid", '0, '0);
      end else begin
        int s;
        string t;
        s = rd % SBN;
        t = op_tag(sb_op[s], sb_tag[s]);
        chk(cyc - sb_cyc[s] == LAT, "R8", "latency",
            VW'(cyc - sb_cyc[s]), VW'(LAT));
        for (int i = 0; i < LANES; i++) begin
          chk(out_data[i*W +: W] == sb_d[s][i*W +: W],
              sb_m[s][i] ? t : "R6", $sformatf("lane %0d data", i),
              VW'(out_data[i*W +: W]), VW'(sb_d[s][i*W +: W]));
        end
        chk(out_flags == sb_f[s], (sb_tag[s] == 7) ? "R7" : "R5", "flags",
            VW'(out_flags), VW'(sb_f[s]));
        rd++;
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, d, t;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(out_valid == 1'b0, "R9", "valid after reset", VW'(out_valid), '0);
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R10: sweep of opcodes, masks, polarity, data sets
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 8; op++)
        for (int m = 0; m < 16; m++)
          for (int e = 0; e < 2; e++) begin
            for (int i = 0; i < LANES; i++) begin
              a[i*W +: W] = gv(k * 131 + op * 17 + m, i, 0);
              b[i*W +: W] = (m % 3 == 0) ? a[i*W +: W] : gv(k * 131 + op * 17 + m, i, 1);
              d[i*W +: W] = gv(k * 131 + op * 17 + m, i, 2);
            end
            issue(3'(op), a, b, d, 4'(m), 1'(e), 0);
          end
    idle(LAT + 2);
    chk(rd == wr, "R8", "all results drained", VW'(rd), VW'(wr));

    // R1: lane 0 overflows, neighbours must not see a carry or borrow
    a = {64'd5, 64'd0, 64'd7, 64'hFFFF_FFFF_FFFF_FFFF};
    b = {64'd5, 64'd0, 64'd2, 64'd1};
    issue(3'd0, a, b, '0, 4'hF, 1'b0, 1);
    issue(3'd1, b, a, '0, 4'hF, 1'b0, 1);
    idle(LAT + 2);

    // R7: then path (add) under m, else path (sub) under ~m onto its result
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i*W +: W] = gv(m + 900, i, 0);
        b[i*W +: W] = gv(m + 900, i, 1);
        d[i*W +: W] = gv(m + 900, i, 2);
        t[i*W +: W] = m[i] ? a[i*W +: W] + b[i*W +: W] : d[i*W +: W];
      end
      issue(3'd0, a, b, d, 4'(m), 1'b0, 0);
      issue(3'd1, a, b, t, 4'(m), 1'b1, 7);
    end
    idle(LAT + 2);
    chk(rd == wr, "R7", "branch results drained", VW'(rd), VW'(wr));

    // R9: reset with instructions in flight
    issue(3'd2, a, b, d, 4'hF, 1'b0, 0);
    issue(3'd0, a, b, d, 4'hF, 1'b0, 0);
    issue(3'd1, a, b, d, 4'hF, 1'b0, 0);
    in_valid = 1'b0;
    rst = 1'b1;
    flushing = 1'b1;
    rd = wr;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "valid during flush", VW'(out_valid), '0);
    rst = 1'b0;
    repeat (LAT + 4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", "no result after flush", VW'(out_valid), '0);
    end
    flushing = 1'b0;

    summary();
    $finish;
  end

endmodule